// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block listens to the command pins of a single-rank SDRAM bus and does not drive it. On every rising clock edge it decodes one command. It keeps a record for each of four banks: whether the bank holds an open row, and how many cycles have passed since that bank was last activated, last precharged and last received write data. It also tracks the spacing since the most recent activate to any bank and since the most recent mode-register load.

A command can break the bank state rules or come too early after an earlier event. When the first such command appears, the monitor raises a flag and stores a code for the broken rule and the bank involved. That record stays in place until software-independent logic pulses a synchronous clear.

Timing limits are given to the block as picosecond minimums together with the clock period. The block turns each one into a cycle count when it is elaborated, so a single netlist can be set up for any bus frequency.

Top module: `sdram_proto_chk`

## Requirements
- R1: A command is decoded only when `cke_i` is high and `cs_ni` is low. The pin pattern {ras_ni,cas_ni,we_ni} decodes as: 000 mode-register load, 001 auto-refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. With `cke_i` low or `cs_ni` high, the cycle is a no-op and no state changes.
- R2: A mode-register load while any bank is open reports code 1. An auto-refresh while any bank is open reports code 2. In both cases the bank field is the lowest-numbered open bank.
- R3: Any command other than a no-op issued fewer than T_MRD_CK (default 2) cycles after a mode-register load reports code 3, with the bank field equal to `ba_i`.
- R4: An activate to a bank that is already open reports code 4. A read or write to a bank that is idle reports code 5.
- R5: An activate issued fewer than tRP cycles after that bank's last precharge reports code 6. An activate issued fewer than tRC cycles after that bank's previous activate reports code 7.
- R6: An activate issued fewer than tRRD cycles after an activate to a different bank reports code 8.
- R7: A read or write issued fewer than tRCD cycles after its bank's activate reports code 9. A precharge of an open bank issued fewer than tRAS cycles after that bank's activate reports code 10.
- R8: A precharge of an open bank issued fewer than T_RDL_CK (default 2) cycles after the last write data to that bank reports code 11. Write data is charged to the bank of the write in the same cycle, or, if there is none, to the bank of the most recent write.
- R9: A precharge with `a10_i` high closes all four banks whatever `ba_i` holds, and applies the R7 and R8 checks to every bank that was open.
- R10: Each cycle limit is the ceiling of the picosecond minimum divided by CLK_PERIOD_PS. With the defaults (15000 ps period) the limits are tRP=2, tRC=6, tRRD=2, tRCD=2 and tRAS=4.
- R11: The first violation sets `err_o` and stores a nonzero code and a bank. These stay unchanged while later violations occur, until `clr_i` is high at an edge. The clear takes priority over a violation in the same cycle.
- R12: When one command breaks several rules, the lowest code is reported. For a precharge that covers several banks, the bank field is the lowest-numbered bank that breaks the reported rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; commands sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the error record |
| cke_i | input | 1 | Clock enable seen on the bus |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10 (all-bank precharge select) |
| wr_vld_i | input | 1 | Write data present on the bus this cycle |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 4 | Code of the first violation (0 when none) |
| err_bank_o | output | 2 | Bank of the first violation |

## Verification
Each result is registered exactly once. A command sampled at edge N therefore shows up on `err_o`, `err_code_o` and `err_bank_o` right after edge N, and a clear takes effect at that same edge. The bench drives inputs on the falling edge. Its behavioural model updates from the same inputs on the rising edge, and the outputs are compared with the model on the next falling edge, half a cycle after they change. Every cycle is checked this way. Spacing is measured in the model as the difference between the edge numbers of the two events, which sets the cycle where each limit applies, both one cycle short of it and exactly on it.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  // Value order is the reporting priority (lowest wins).
  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_MRS_OPEN = 4'd1,
    ERR_REF_OPEN = 4'd2,
    ERR_MRD      = 4'd3,
    ERR_ACT_OPEN = 4'd4,
    ERR_RW_IDLE  = 4'd5,
    ERR_TRP      = 4'd6,
    ERR_TRC      = 4'd7,
    ERR_TRRD     = 4'd8,
    ERR_TRCD     = 4'd9,
    ERR_TRAS     = 4'd10,
    ERR_TRDL     = 4'd11
  } err_e;

  function automatic int ps_to_clk(int ps, int period_ps);
    return (ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_sat_cnt.sv
module sdram_sat_cnt #(
  parameter int W   = 3,
  parameter int SAT = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT_V = W'(SAT);
  localparam logic [W-1:0] ONE_V = W'(1);

  // Reset to saturation: no event seen yet counts as long ago.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= SAT_V;
    else if (load_i)          cnt_o <= ONE_V;
    else if (cnt_o != SAT_V)  cnt_o <= cnt_o + ONE_V;
  end
endmodule

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
  import sdram_chk_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cke_i && !cs_ni) cmd_o = cmd_e'({ras_ni, cas_ni, we_ni});
    else                 cmd_o = CMD_NOP;
  end
endmodule

// File: rtl/sdram_bank_trk.sv
module sdram_bank_trk #(
  parameter int CW  = 3,
  parameter int SAT = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic          wdat_i,
  output logic          open_o,
  output logic [CW-1:0] act_cnt_o,
  output logic [CW-1:0] pre_cnt_o,
  output logic [CW-1:0] wdat_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_o <= 1'b0;
    else if (act_i)  open_o <= 1'b1;
    else if (pre_i)  open_o <= 1'b0;
  end

  sdram_sat_cnt #(.W(CW), .SAT(SAT)) u_act_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .cnt_o(act_cnt_o)
  );
  sdram_sat_cnt #(.W(CW), .SAT(SAT)) u_pre_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(pre_i), .cnt_o(pre_cnt_o)
  );
  sdram_sat_cnt #(.W(CW), .SAT(SAT)) u_wdat_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wdat_i), .cnt_o(wdat_cnt_o)
  );
endmodule

// File: rtl/sdram_proto_chk.sv
module sdram_proto_chk
  import sdram_chk_pkg::*;
#(
  parameter int BA_W          = 2,
  parameter int CLK_PERIOD_PS = 15000,
  parameter int T_RP_PS       = 24000,
  parameter int T_RC_PS       = 80000,
  parameter int T_RRD_PS      = 20000,
  parameter int T_RCD_PS      = 24000,
  parameter int T_RAS_PS      = 50000,
  parameter int T_MRD_CK      = 2,
  parameter int T_RDL_CK      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  logic            wr_vld_i,
  output logic            err_o,
  output logic [3:0]      err_code_o,
  output logic [BA_W-1:0] err_bank_o
);
  localparam int NB    = 1 << BA_W;
  localparam int L_RP  = ps_to_clk(T_RP_PS,  CLK_PERIOD_PS);
  localparam int L_RC  = ps_to_clk(T_RC_PS,  CLK_PERIOD_PS);
  localparam int L_RRD = ps_to_clk(T_RRD_PS, CLK_PERIOD_PS);
  localparam int L_RCD = ps_to_clk(T_RCD_PS, CLK_PERIOD_PS);
  localparam int L_RAS = ps_to_clk(T_RAS_PS, CLK_PERIOD_PS);
  localparam int L_MAX = max_int(max_int(max_int(L_RP, L_RC), max_int(L_RRD, L_RCD)),
                                 max_int(max_int(L_RAS, T_MRD_CK), T_RDL_CK));
  localparam int CW    = $clog2(L_MAX + 1);

  localparam logic [CW-1:0] LIM_RP  = CW'(L_RP);
  localparam logic [CW-1:0] LIM_RC  = CW'(L_RC);
  localparam logic [CW-1:0] LIM_RRD = CW'(L_RRD);
  localparam logic [CW-1:0] LIM_RCD = CW'(L_RCD);
  localparam logic [CW-1:0] LIM_RAS = CW'(L_RAS);
  localparam logic [CW-1:0] LIM_MRD = CW'(T_MRD_CK);
  localparam logic [CW-1:0] LIM_RDL = CW'(T_RDL_CK);

  function automatic logic [BA_W-1:0] lowest_set(logic [NB-1:0] v);
    logic [BA_W-1:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--) if (v[i]) r = BA_W'(i);
    return r;
  endfunction

  cmd_e cmd;
  sdram_cmd_dec u_dec (
    .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  logic            is_act, is_pre, is_rw;
  logic [BA_W-1:0] wr_bank_q, wdat_bank, act_bank_q;
  logic [CW-1:0]   act_any_cnt, mrs_cnt;

  assign is_act    = (cmd == CMD_ACT);
  assign is_pre    = (cmd == CMD_PRE);
  assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign wdat_bank = (cmd == CMD_WR) ? ba_i : wr_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q  <= '0;
      act_bank_q <= '0;
    end else begin
      if (cmd == CMD_WR) wr_bank_q  <= ba_i;
      if (is_act)        act_bank_q <= ba_i;
    end
  end

  sdram_sat_cnt #(.W(CW), .SAT(L_MAX)) u_act_any_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_act), .cnt_o(act_any_cnt)
  );
  sdram_sat_cnt #(.W(CW), .SAT(L_MAX)) u_mrs_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_MRS), .cnt_o(mrs_cnt)
  );

  logic [NB-1:0] bank_open, ras_viol, rdl_viol;
  logic [CW-1:0] act_cnt  [NB];
  logic [CW-1:0] pre_cnt  [NB];
  logic [CW-1:0] wdat_cnt [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit_act, hit_pre, hit_wdat;
    assign hit_act  = is_act && (ba_i == BA_W'(b));
    assign hit_pre  = is_pre && (a10_i || (ba_i == BA_W'(b)));
    assign hit_wdat = wr_vld_i && (wdat_bank == BA_W'(b));

    sdram_bank_trk #(.CW(CW), .SAT(L_MAX)) u_trk (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .act_i(hit_act), .pre_i(hit_pre), .wdat_i(hit_wdat),
      .open_o(bank_open[b]), .act_cnt_o(act_cnt[b]),
      .pre_cnt_o(pre_cnt[b]), .wdat_cnt_o(wdat_cnt[b])
    );

    assign ras_viol[b] = hit_pre && bank_open[b] && (act_cnt[b]  < LIM_RAS);
    assign rdl_viol[b] = hit_pre && bank_open[b] && (wdat_cnt[b] < LIM_RDL);
  end

  err_e            viol_code;
  logic [BA_W-1:0] viol_bank;
  logic            any_open, sel_open;
  assign any_open = |bank_open;
  assign sel_open = bank_open[ba_i];

  // Ordered by code value so the lowest code wins.
  always_comb begin
    viol_code = ERR_NONE;
    viol_bank = ba_i;
    if ((cmd == CMD_MRS) && any_open) begin
      viol_code = ERR_MRS_OPEN;
      viol_bank = lowest_set(bank_open);
    end else if ((cmd == CMD_REF) && any_open) begin
      viol_code = ERR_REF_OPEN;
      viol_bank = lowest_set(bank_open);
    end else if ((cmd != CMD_NOP) && (mrs_cnt < LIM_MRD)) begin
      viol_code = ERR_MRD;
    end else if (is_act && sel_open) begin
      viol_code = ERR_ACT_OPEN;
    end else if (is_rw && !sel_open) begin
      viol_code = ERR_RW_IDLE;
    end else if (is_act && (pre_cnt[ba_i] < LIM_RP)) begin
      viol_code = ERR_TRP;
    end else if (is_act && (act_cnt[ba_i] < LIM_RC)) begin
      viol_code = ERR_TRC;
    end else if (is_act && (ba_i != act_bank_q) && (act_any_cnt < LIM_RRD)) begin
      viol_code = ERR_TRRD;
    end else if (is_rw && (act_cnt[ba_i] < LIM_RCD)) begin
      viol_code = ERR_TRCD;
    end else if (|ras_viol) begin
      viol_code = ERR_TRAS;
      viol_bank = lowest_set(ras_viol);
    end else if (|rdl_viol) begin
      viol_code = ERR_TRDL;
      viol_bank = lowest_set(rdl_viol);
    end
  end

  err_e err_code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_q <= ERR_NONE;
      err_bank_o <= '0;
    end else if (clr_i) begin
      err_o      <= 1'b0;
      err_code_q <= ERR_NONE;
      err_bank_o <= '0;
    end else if (!err_o && (viol_code != ERR_NONE)) begin
      err_o      <= 1'b1;
      err_code_q <= viol_code;
      err_bank_o <= viol_bank;
    end
  end
  assign err_code_o = err_code_q;

endmodule

// File: rtl/sdram_proto_chk_sva.sv
module sdram_proto_chk_sva #(
  parameter int BA_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic            cke_i,
  input logic            cs_ni,
  input logic            ras_ni,
  input logic            cas_ni,
  input logic            we_ni,
  input logic [BA_W-1:0] ba_i,
  input logic            err_o,
  input logic [3:0]      err_code_o
);
  logic sel, is_mrs, is_act, non_nop;
  assign sel     = cke_i && !cs_ni;
  assign is_mrs  = sel && ({ras_ni, cas_ni, we_ni} == 3'b000);
  assign is_act  = sel && ({ras_ni, cas_ni, we_ni} == 3'b011);
  assign non_nop = sel && ({ras_ni, cas_ni, we_ni} != 3'b111);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> (err_o && $stable(err_code_o)));

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!err_o && (err_code_o == 4'd0)));

  assert_code_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (err_code_o != 4'd0));

  // Holds for T_MRD_CK >= 2 (the default).
  assert_mrd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (non_nop && !clr_i && $past(is_mrs && !clr_i)) |=> err_o);

  assert_act_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && !clr_i && $past(is_act && !clr_i) && $stable(ba_i)) |=> err_o);
endmodule

bind sdram_proto_chk sdram_proto_chk_sva #(.BA_W(BA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .cke_i(cke_i),
  .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
  .ba_i(ba_i), .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/sim_sdram_proto_chk.sv
`timescale 1ns/1ps
module sim_sdram_proto_chk;
  localparam int CLK_NS = 10;
  localparam int PER    = 15000;
  localparam int LRP    = (24000 + PER - 1) / PER;
  localparam int LRC    = (80000 + PER - 1) / PER;
  localparam int LRRD   = (20000 + PER - 1) / PER;
  localparam int LRCD   = (24000 + PER - 1) / PER;
  localparam int LRAS   = (50000 + PER - 1) / PER;
  localparam int LMRD   = 2;
  localparam int LRDL   = 2;

  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011,
                         WR = 3'b100, RD = 3'b101, BST = 3'b110, NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0, wv = 1'b0;
  logic err;
  logic [3:0] code;
  logic [1:0] bank;

  always #(CLK_NS/2) clk = ~clk;

  sdram_proto_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .cke_i(cke), .cs_ni(cs_n),
    .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10),
    .wr_vld_i(wv), .err_o(err), .err_code_o(code), .err_bank_o(bank)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  // Behavioural reference model: event timestamps per bank.
  int cyc, t_mrs, t_act_any, act_bank_m, wr_bank_m;
  int open_m [4];
  int t_act [4];
  int t_pre [4];
  int t_wd  [4];
  int exp_err, exp_code, exp_bank;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; t_mrs = -1000; t_act_any = -1000; act_bank_m = 0; wr_bank_m = 0;
      for (int i = 0; i < 4; i++) begin
        open_m[i] = 0; t_act[i] = -1000; t_pre[i] = -1000; t_wd[i] = -1000;
      end
      exp_err = 0; exp_code = 0; exp_bank = 0;
    end else begin
      int c, b, vc, vb, any, low, wb;
      bit rw;
      cyc++;
      c = (cke && !cs_n) ? int'({ras_n, cas_n, we_n}) : 7;
      b = int'(ba);
      rw = (c == 4) || (c == 5);
      any = 0; low = 0;
      for (int i = 3; i >= 0; i--) if (open_m[i] != 0) begin any = 1; low = i; end
      vc = 0; vb = b;
      if (c == 0 && any != 0) begin vc = 1; vb = low; end
      else if (c == 1 && any != 0) begin vc = 2; vb = low; end
      else if (c != 7 && cyc - t_mrs < LMRD) vc = 3;
      else if (c == 3 && open_m[b] != 0) vc = 4;
      else if (rw && open_m[b] == 0) vc = 5;
      else if (c == 3 && cyc - t_pre[b] < LRP) vc = 6;
      else if (c == 3 && cyc - t_act[b] < LRC) vc = 7;
      else if (c == 3 && b != act_bank_m && cyc - t_act_any < LRRD) vc = 8;
      else if (rw && cyc - t_act[b] < LRCD) vc = 9;
      else if (c == 2) begin
        for (int i = 3; i >= 0; i--)
          if ((a10 || i == b) && open_m[i] != 0 && cyc - t_act[i] < LRAS) begin vc = 10; vb = i; end
        if (vc == 0)
          for (int i = 3; i >= 0; i--)
            if ((a10 || i == b) && open_m[i] != 0 && cyc - t_wd[i] < LRDL) begin vc = 11; vb = i; end
      end
      if (clr) begin exp_err = 0; exp_code = 0; exp_bank = 0; end
      else if (exp_err == 0 && vc != 0) begin exp_err = 1; exp_code = vc; exp_bank = vb; end
      wb = (c == 4) ? b : wr_bank_m;
      if (wv) t_wd[wb] = cyc;
      if (c == 4) wr_bank_m = b;
      if (c == 0) t_mrs = cyc;
      if (c == 3) begin open_m[b] = 1; t_act[b] = cyc; t_act_any = cyc; act_bank_m = b; end
      if (c == 2)
        for (int i = 0; i < 4; i++)
          if (a10 || i == b) begin open_m[i] = 0; t_pre[i] = cyc; end
    end
  end

  task automatic compare();
    n_chk++;
    if (int'(err) != exp_err || int'(code) != exp_code || (exp_err != 0 && int'(bank) != exp_bank)) begin
      n_bad++;
      $display("FAIL %s @cyc %0d: err/code/bank actual %0d/%0d/%0d expected %0d/%0d/%0d",
               cur_req, cyc, err, code, bank, exp_err, exp_code, exp_bank);
    end
  endtask

  task automatic raw(input logic k, input logic s, input logic [2:0] c,
                     input logic [1:0] b, input logic a, input logic w, input logic cl);
    @(negedge clk);
    compare();
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = c; ba = b; a10 = a; wv = w; clr = cl;
  endtask

  task automatic cmd(input logic [2:0] c, input logic [1:0] b, input logic a, input logic w);
    raw(1'b1, 1'b0, c, b, a, w, 1'b0);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) cmd(NOP, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic clear();
    raw(1'b1, 1'b0, NOP, 2'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic close_all();
    clear(); nop(5); cmd(PRE, 2'd0, 1'b1, 1'b0); nop(6); clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; nop(3);                          // reset state
    cur_req = "R3"; cmd(MRS, 0, 0, 0); cmd(ACT, 0, 0, 0); nop(2); clear(); nop(3);
    cur_req = "R2"; cmd(MRS, 1, 0, 0); nop(2); clear(); nop(2);
    cmd(REF, 2, 0, 0); nop(1); clear();
    cur_req = "R1";                                  // ignored patterns while bank 0 open
    raw(1'b1, 1'b1, ACT, 0, 0, 0, 0); raw(1'b0, 1'b0, MRS, 0, 0, 0, 0); nop(2);
    cur_req = "R3"; close_all(); cmd(MRS, 0, 0, 0); cmd(BST, 3, 0, 0); nop(1); clear();
    cmd(MRS, 0, 0, 0); nop(1); cmd(ACT, 1, 0, 0); nop(2);  // on the limit: legal
    cur_req = "R6"; close_all(); cmd(ACT, 1, 0, 0); cmd(ACT, 2, 0, 0); nop(2); clear();
    close_all(); cmd(ACT, 1, 0, 0); nop(1); cmd(ACT, 2, 0, 0); nop(2);  // legal spacing
    cur_req = "R4"; cmd(ACT, 1, 0, 0); nop(1); clear(); cmd(RD, 3, 0, 0); nop(1); clear();
    cur_req = "R7"; nop(3); cmd(ACT, 3, 0, 0); cmd(RD, 3, 0, 0); clear(); cmd(PRE, 3, 0, 0); clear();
    cur_req = "R5"; close_all(); cmd(ACT, 1, 0, 0); nop(5); cmd(PRE, 1, 0, 0); cmd(ACT, 1, 0, 0); nop(1); clear();
    close_all(); cmd(ACT, 0, 0, 0); cmd(PRE, 0, 0, 0); clear(); cmd(ACT, 0, 0, 0); nop(1); clear();
    cur_req = "R8"; close_all(); cmd(ACT, 2, 0, 0); nop(2); cmd(WR, 2, 0, 1); cmd(NOP, 0, 0, 1);
    cmd(PRE, 2, 0, 0); nop(1); clear();
    close_all(); cmd(ACT, 2, 0, 0); nop(2); cmd(WR, 2, 0, 1); cmd(NOP, 0, 0, 1); nop(1);
    cmd(PRE, 2, 0, 0); nop(2);                       // on the limit: legal
    cur_req = "R9"; close_all(); cmd(ACT, 1, 0, 0); nop(1); cmd(ACT, 3, 0, 0); nop(2);
    cmd(PRE, 0, 1, 0); clear(); cmd(RD, 1, 0, 0); nop(1); clear();
    cur_req = "R12"; close_all(); cmd(ACT, 2, 0, 0); nop(1); cmd(ACT, 3, 0, 0); cmd(PRE, 0, 1, 0); nop(1); clear();
    cur_req = "R11"; close_all(); cmd(RD, 0, 0, 0); cmd(MRS, 0, 0, 0); cmd(REF, 0, 0, 0); nop(2);
    raw(1'b1, 1'b0, RD, 1, 0, 0, 1); nop(2);         // clear wins over same-cycle violation
    cur_req = "R10"; cmd(ACT, 0, 0, 0); nop(1); cmd(RD, 0, 0, 0); nop(1); cmd(PRE, 0, 0, 0); nop(2);
    nop(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule